// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This peripheral watches over system software. Software programs a range value that sets a down-counter period of a power of two clock cycles. It then sets an enable bit that cannot be cleared again except by the block's own reset. Software must keep the counter from reaching zero by writing a fixed key value to a restart register. If it fails to do so, the block either pulses a system reset output at once, or first raises an interrupt. In the interrupt-first mode, the reset pulse follows only if the interrupt is still unacknowledged when the counter runs out a second time.

Access is through a simple 32-bit register bus with single-cycle reads and writes. Read data is combinational while the read strobe is high. Reading the acknowledge register has two side effects: it clears the pending interrupt and it restarts the counter. The base exponent of the period is a parameter. The default of 16 gives periods from 2^16 to 2^31 cycles.

Top module: `wdog_core`

## Requirements
- R1: After reset the enable bit, mode bit, range value, counter value and interrupt status all read 0, and irq_o and sys_rst_o are low.
- R2: Offset 0x00 holds the enable in bit 0 and the response mode in bit 1. Writing bit 0 as 1 sets the enable, and no later bus write clears it. The mode bit follows every write.
- R3: When the enable goes from 0 to 1, the counter (read at offset 0x08) loads 2^(S+N)-1, where S is BASE_SHIFT and N is the range value. While enabled, the counter decrements by one every cycle. While disabled, it holds its value.
- R4: With no restart, the counter runs out exactly 2^(S+N) cycles after the enabling write, and at that point it reloads the full period.
- R5: Writing 0x76 to offset 0x0C reloads the counter with the full period. Writing any other value there leaves the counter counting down undisturbed.
- R6: Offset 0x04 holds a 4-bit range value N, from bits 3:0 of the write data. A new value is used only from the next reload onward.
- R7: In mode 0, a run-out drives sys_rst_o high for exactly 8 cycles, and irq_o stays low.
- R8: In mode 1, a run-out with no interrupt pending sets the pending interrupt (irq_o high, offset 0x10 bit 0 reads 1) and does not assert sys_rst_o.
- R9: In mode 1, a run-out while the interrupt is still pending starts the 8-cycle sys_rst_o pulse.
- R10: A read of offset 0x14 clears the pending interrupt and reloads the counter with the full period.
- R11: A restart write or an acknowledge read in the same cycle that the counter reaches its run-out takes priority. Neither an interrupt nor a reset is raised, and the counter holds the full period afterwards.
- R12: Reads of offsets 0x0C, 0x14 and every unmapped offset return 0. Writes to offsets 0x08, 0x10 and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, 0 otherwise |
| irq_o | output | 1 | Pending interrupt, level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The counter's run-out and a software reload (a key write to the restart register or an acknowledge read) can fall on the same clock edge. The bench provokes this by counting cycles from the enabling write, so that the key write lands exactly when the counter reads 0. It also places an acknowledge read on the edge of a second run-out with the interrupt pending. In both cases it judges the outcome at the ports: irq_o and sys_rst_o must stay low, and the counter must read back the full period minus nothing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_ACK   = 8'h14;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RANGE_W = 4,
  parameter int CNT_W   = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd,
  output logic [DATA_W-1:0]  rdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               pend,
  output logic               en,
  output logic               mode,
  output logic [RANGE_W-1:0] range,
  output logic               kick,
  output logic               ack,
  output logic               start
);
  ctrl_t              ctrl_q, ctrl_d;
  logic [RANGE_W-1:0] range_q, range_d;
  logic               wr_ctrl, wr_range;

  always_comb begin
    wr_ctrl  = wr && (addr == OFS_CTRL);
    wr_range = wr && (addr == OFS_RANGE);
    ctrl_d   = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en   = ctrl_q.en | wdata[0];
      ctrl_d.mode = wdata[1];
    end
    range_d = wdata[RANGE_W-1:0];
    start   = wr_ctrl && wdata[0] && !ctrl_q.en;
    kick    = wr && (addr == OFS_KICK) && (wdata == DATA_W'(KICK_KEY));
    ack     = rd && (addr == OFS_ACK);
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        OFS_CTRL:  rdata = DATA_W'({ctrl_q.mode, ctrl_q.en});
        OFS_RANGE: rdata = DATA_W'(range_q);
        OFS_COUNT: rdata = DATA_W'(cnt);
        OFS_STAT:  rdata = DATA_W'(pend);
        default:   rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      range_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
      if (wr_range) range_q <= range_d;
    end
  end

  assign en    = ctrl_q.en;
  assign mode  = ctrl_q.mode;
  assign range = range_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int RANGE_W    = 4,
  parameter int BASE_SHIFT = 16,
  parameter int CNT_W      = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               reload,
  input  logic [RANGE_W-1:0] range,
  output logic [CNT_W-1:0]   cnt,
  output logic               expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, full_val;
  logic [CNT_W:0]   span;
  logic             cnt_ce;

  always_comb begin
    span     = (CNT_W+1)'(1) << (BASE_SHIFT + int'(range));
    full_val = CNT_W'(span - 1'b1);
    expire   = en && (cnt_q == '0) && !reload;
    cnt_ce   = en || reload;
    if (reload || expire) cnt_d = full_val;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic mode,
  input  logic ack,
  output logic irq,
  output logic sys_rst
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic          pend_q, pend_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          fire;

  always_comb begin
    fire   = expire && (!mode || pend_q);
    pend_d = pend_q;
    if (ack)                          pend_d = 1'b0;
    else if (expire && mode && !pend_q) pend_d = 1'b1;
    if (fire)                 pulse_d = PW'(RST_CYCLES);
    else if (pulse_q != '0)   pulse_d = pulse_q - 1'b1;
    else                      pulse_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign irq     = pend_q;
  assign sys_rst = (pulse_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RANGE_W    = 4,
  parameter int BASE_SHIFT = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int CNT_W = BASE_SHIFT + (1 << RANGE_W) - 1;

  logic [1:0]         rs_q;
  logic               rst_core_n;
  logic               en, mode, kick, ack, start, reload, expire;
  logic [RANGE_W-1:0] range;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign reload = start || (en && (kick || ack));

  wdog_regs #(.DATA_W(DATA_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rd(bus_rd), .rdata(bus_rdata), .cnt(cnt),
    .pend(irq_o), .en(en), .mode(mode), .range(range), .kick(kick),
    .ack(ack), .start(start)
  );

  wdog_counter #(.RANGE_W(RANGE_W), .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .en(en), .reload(reload),
    .range(range), .cnt(cnt), .expire(expire)
  );

  wdog_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk(clk), .rst_n(rst_core_n), .expire(expire), .mode(mode),
    .ack(ack), .irq(irq_o), .sys_rst(sys_rst_o)
  );
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 31,
  parameter int RST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              en,
  input logic              mode,
  input logic [CNT_W-1:0]  cnt,
  input logic              irq_o,
  input logic              sys_rst_o
);
  localparam int HW = $clog2(RST_CYCLES + 2);

  logic          kick_in, ack_in;
  logic [HW-1:0] hi_len;

  assign kick_in = bus_wr && (bus_addr == OFS_KICK) && (bus_wdata == DATA_W'(KICK_KEY));
  assign ack_in  = bus_rd && (bus_addr == OFS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   hi_len <= '0;
    else if (!sys_rst_o)                          hi_len <= '0;
    else if (hi_len != HW'(RST_CYCLES + 1))       hi_len <= hi_len + 1'b1;
  end

  a_r2_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> $stable(cnt));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt != '0) && !kick_in && !ack_in) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (hi_len < HW'(RST_CYCLES)));

  a_r8_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(mode));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in |=> !irq_o);
endmodule

bind wdog_core wdog_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .en(en), .mode(mode), .cnt(cnt),
  .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wdog_core.sv
module tb_wdog_core;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;
  localparam int P0         = 1 << BASE;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        sys_rst_o;

  int n_tests = 0;
  int n_fail  = 0;

  wdog_core #(.BASE_SHIFT(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // op(1=write,0=read), offset, write data or expected read data
  localparam int NV = 20;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0},   // R1 ctrl after reset
    {1'b0, 8'h04, 32'h0},   // R1 range after reset
    {1'b0, 8'h10, 32'h0},   // R1 status after reset
    {1'b1, 8'h04, 32'h1A},  // R6 range takes bits 3:0
    {1'b0, 8'h04, 32'hA},   // R6
    {1'b1, 8'h08, 32'h55},  // R12 write to counter ignored
    {1'b0, 8'h08, 32'h0},   // R12
    {1'b1, 8'h10, 32'h1},   // R12 write to status ignored
    {1'b0, 8'h10, 32'h0},   // R12
    {1'b0, 8'h18, 32'h0},   // R12 unmapped read
    {1'b0, 8'h3C, 32'h0},   // R12 unmapped read
    {1'b0, 8'h0C, 32'h0},   // R12 restart reads 0
    {1'b1, 8'h00, 32'h2},   // R2 mode only
    {1'b0, 8'h00, 32'h2},   // R2
    {1'b1, 8'h00, 32'h1},   // R2 enable, mode cleared
    {1'b0, 8'h00, 32'h1},   // R2
    {1'b1, 8'h00, 32'h0},   // R2 try to clear enable
    {1'b0, 8'h00, 32'h1},   // R2 enable sticky
    {1'b1, 8'h00, 32'h2},   // R2 mode set again
    {1'b0, 8'h00, 32'h3}    // R2
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    chk({31'b0, irq_o}, 0, "R1 irq_o");
    chk({31'b0, sys_rst_o}, 0, "R1 sys_rst_o");
    rd(8'h08, v); chk(v, 0, "R1 counter");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][39:32], v);
        chk(v, VEC[i][31:0], $sformatf("R1/R2/R6/R12 vector %0d", i));
      end
    end

    // R3 R4 R7: mode 0 run-out
    do_reset();
    wr(8'h00, 32'h1);                 // k=0
    rd(8'h08, v); chk(v, P0-1, "R3 load");   // k=0 -> 1
    rd(8'h08, v); chk(v, P0-2, "R3 decrement"); // k=1 -> 2
    repeat (13) @(negedge clk);        // k=15
    chk({31'b0, sys_rst_o}, 0, "R4 before run-out");
    @(negedge clk);                   // k=16
    for (int i = 0; i < 8; i++) begin
      chk({31'b0, sys_rst_o}, 1, "R7 pulse high");
      chk({31'b0, irq_o}, 0, "R7 no irq");
      if (i == 0) begin
        rd(8'h08, v); chk(v, P0-1, "R4 reload");
      end else @(negedge clk);
    end
    chk({31'b0, sys_rst_o}, 0, "R7 pulse ends");

    // R5 R6: restart key and range at reload
    do_reset();
    wr(8'h00, 32'h1);                 // k=0
    repeat (5) @(negedge clk);         // k=5
    wr(8'h0C, 32'h12);                // k=6
    rd(8'h08, v); chk(v, P0-1-6, "R5 wrong key ignored"); // k=7
    wr(8'h04, 32'h1);                 // k=8
    rd(8'h08, v); chk(v, P0-1-8, "R6 range not yet used"); // k=9
    wr(8'h0C, 32'h76);                // k=10
    rd(8'h08, v); chk(v, 2*P0-1, "R5 R6 restart with new range");
    chk({31'b0, sys_rst_o}, 0, "R5 no reset");

    // R8 R9: mode 1 two-stage
    do_reset();
    wr(8'h00, 32'h3);                 // k=0
    repeat (16) @(negedge clk);        // k=16
    chk({31'b0, irq_o}, 1, "R8 irq raised");
    chk({31'b0, sys_rst_o}, 0, "R8 no reset");
    rd(8'h10, v); chk(v, 1, "R8 status");     // k=17
    rd(8'h08, v); chk(v, P0-2, "R8 reloaded"); // k=18
    repeat (13) @(negedge clk);        // k=31
    chk({31'b0, sys_rst_o}, 0, "R9 before second run-out");
    @(negedge clk);                   // k=32
    chk({31'b0, sys_rst_o}, 1, "R9 reset on second run-out");
    chk({31'b0, irq_o}, 1, "R9 irq still pending");

    // R10: acknowledge
    do_reset();
    wr(8'h00, 32'h3);
    repeat (16) @(negedge clk);        // k=16
    rd(8'h14, v); chk(v, 0, "R12 ack reads 0"); // k=17
    chk({31'b0, irq_o}, 0, "R10 irq cleared");
    rd(8'h08, v); chk(v, P0-1, "R10 counter reloaded"); // k=18
    rd(8'h10, v); chk(v, 0, "R10 status cleared");     // k=19
    repeat (14) @(negedge clk);        // k=33
    chk({31'b0, irq_o}, 1, "R10 next run-out raises irq");
    chk({31'b0, sys_rst_o}, 0, "R10 no reset after ack");

    // R11: restart on the run-out edge, mode 0
    do_reset();
    wr(8'h00, 32'h1);
    repeat (15) @(negedge clk);        // k=15, counter 0
    wr(8'h0C, 32'h76);                // k=16
    chk({31'b0, sys_rst_o}, 0, "R11 kick beats run-out");
    rd(8'h08, v); chk(v, P0-1, "R11 counter full after kick");

    // R11: acknowledge on the second run-out edge, mode 1
    do_reset();
    wr(8'h00, 32'h3);
    repeat (31) @(negedge clk);        // k=31
    rd(8'h14, v);                     // k=32
    chk({31'b0, irq_o}, 0, "R11 ack beats run-out irq");
    chk({31'b0, sys_rst_o}, 0, "R11 ack beats run-out reset");
    rd(8'h08, v); chk(v, P0-1, "R11 counter full after ack");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule